// File: doc/BRIEF.md
# Pipelined Carry-Save Array Multiplier

This block multiplies two unsigned operands (8 bits each by default) and returns their full-width product (16 bits by default). A registered front stage forms one shifted partial product for every bit of the multiplier operand. A tree of 3:2 carry-save adders then reduces those rows, with a register after every tree level, until only a sum row and a carry row remain. A single carry-propagate adder in the last stage adds them into the product.

Every register in the pipeline captures on the same clock edge, and the pipeline never stalls. A new operand pair can therefore enter on every clock. A valid flag travels beside the data, so the caller sees the product of each accepted pair exactly a fixed number of cycles later. Cycles in which nothing is accepted appear at the output as cycles in which nothing is valid. The number of tree levels, and so the latency, follows from the multiplier operand width. For the default 8-bit operands the tree reduces 8 rows to 6, then 4, then 3, then 2, which gives four levels and a latency of 6 cycles.

Top module: `csa_mul_top`

## Requirements
- R1: Whenever `out_valid` is 1, `product` equals the unsigned product `a*b` of the pair accepted with the matching input, for every one of the 65536 operand pairs at the default widths.
- R2: A pair accepted with `in_valid`=1 at a rising edge yields `out_valid`=1 exactly 6 rising edges later at the default widths, which is one partial-product stage, four reduction levels and one final-add stage.
- R3: Pairs presented on consecutive clocks with no gaps emerge on consecutive clocks, in the same order, one product per clock.
- R4: While `rst_n` is 0, and afterwards until the first accepted pair has reached the output, `out_valid` is 0. During reset `product` is 0.
- R5: A cycle with `in_valid`=0 produces a cycle with `out_valid`=0 at the output position that matches it. No extra valid outputs appear.
- R6: Partial-product row i holds operand `a` shifted left by i when bit i of `b` is 1, and holds zero otherwise, so a multiplier with exactly one bit set gives `a` shifted by that bit position.
- R7: Each carry-save level keeps the sum of its rows (modulo 2^16) unchanged while it reduces the number of rows, and each carry row is shifted left by one bit. This holds even when every row carries all ones, as with a=255 and b=255 giving 65025.
- R8: The extreme operands give exact results: 0*x is 0, x*0 is 0, 1*x is x, and 255*255 is 65025.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every pipeline register captures on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Marks the pair on `a` and `b` as accepted at this edge |
| a | input | A_W (8) | Multiplicand, unsigned |
| b | input | B_W (8) | Multiplier, unsigned; each bit selects one partial-product row |
| out_valid | output | 1 | Marks `product` as the result of an accepted pair |
| product | output | A_W+B_W (16) | Unsigned product |

## Verification
The hardest situation to reach from the ports is a full pipeline in which every stage holds a different pair and gaps sit between some of them. In that state a slip of a single cycle in any level's valid flag, or a mixed-up carry row, would pair a product with the wrong operands. The stimulus sweeps all 65536 pairs back to back and inserts a single idle cycle after every 97th pair. Every stage is therefore kept busy, and bubbles pass through each level at shifting phases. A scoreboard stamps each pair with its issue cycle and checks both the value and the exact arrival cycle. Directed pairs with a single-bit multiplier, zeros and all ones come first, to isolate the partial-product stage and the carry paths with the largest carries.

// File: rtl/csa_mul_pkg.sv
package csa_mul_pkg;

   // Rows left after one level of 3:2 reduction: each full group of three rows
   // becomes two, and leftover rows pass through unchanged.
   function automatic int next_rows(input int n);
      return (n / 3) * 2 + (n % 3);
   endfunction

   // Row count entering tree level lvl, starting from n0 partial products.
   function automatic int level_rows(input int n0, input int lvl);
      int n;
      n = n0;
      for (int i = 0; i < lvl; i++) n = next_rows(n);
      return n;
   endfunction

   // Number of reduction levels needed to reach two rows.
   function automatic int num_levels(input int n0);
      int n;
      int k;
      n = n0;
      k = 0;
      while (n > 2) begin
         n = next_rows(n);
         k++;
      end
      return k;
   endfunction

endpackage

// File: rtl/csa_mul_cell.sv
module csa_mul_cell #(
   parameter int W = 16
) (
   input  logic [W-1:0] x,
   input  logic [W-1:0] y,
   input  logic [W-1:0] z,
   output logic [W-1:0] s,
   output logic [W-1:0] c
);
   // Bitwise full adders. There is no carry chain: each carry moves to the
   // next weight as a separate row.
   always_comb begin
      s = x ^ y ^ z;
      c = ((x & y) | (x & z) | (y & z)) << 1;
   end
endmodule

// File: rtl/csa_mul_pp.sv
module csa_mul_pp #(
   parameter int A_W = 8,
   parameter int B_W = 8,
   parameter int W   = A_W + B_W
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    v_i,
   input  logic [A_W-1:0]          a_i,
   input  logic [B_W-1:0]          b_i,
   output logic                    v_o,
   output logic [B_W-1:0][W-1:0]   rows_o
);
   logic [B_W-1:0][W-1:0] rows_d;
   logic [W-1:0]          a_ext;

   assign a_ext = {{(W-A_W){1'b0}}, a_i};

   for (genvar i = 0; i < B_W; i++) begin : g_row
      assign rows_d[i] = b_i[i] ? (a_ext << i) : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_o    <= 1'b0;
         rows_o <= '0;
      end else begin
         v_o    <= v_i;
         rows_o <= rows_d;
      end
   end

   a_r2_pp_valid: assert property (@(posedge clk) disable iff (!rst_n)
      v_o == $past(v_i));

   for (genvar i = 0; i < B_W; i++) begin : g_chk
      a_r6_row_bits: assert property (@(posedge clk) disable iff (!rst_n)
         v_o |-> ($countones(rows_o[i]) ==
                  ($past(b_i[i]) ? $countones($past(a_i)) : 0)));
   end
endmodule

// File: rtl/csa_mul_level.sv
module csa_mul_level #(
   parameter int W    = 16,
   parameter int ROWS = 8,
   parameter int N_IN = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    v_i,
   input  logic [ROWS-1:0][W-1:0]  rows_i,
   output logic                    v_o,
   output logic [ROWS-1:0][W-1:0]  rows_o
);
   localparam int N_GRP = N_IN / 3;
   localparam int N_REM = N_IN % 3;
   localparam int N_OUT = N_GRP * 2 + N_REM;

   if (N_IN < 3 || N_IN > ROWS) begin : g_bad_rows
      $error("csa_mul_level: N_IN must be in 3..ROWS");
   end

   logic [ROWS-1:0][W-1:0] rows_d;

   for (genvar g = 0; g < N_GRP; g++) begin : g_csa
      csa_mul_cell #(.W(W)) u_cell (
         .x (rows_i[3*g]),
         .y (rows_i[3*g+1]),
         .z (rows_i[3*g+2]),
         .s (rows_d[2*g]),
         .c (rows_d[2*g+1])
      );
   end

   for (genvar r = 0; r < N_REM; r++) begin : g_pass
      assign rows_d[2*N_GRP+r] = rows_i[3*N_GRP+r];
   end

   for (genvar r = N_OUT; r < ROWS; r++) begin : g_zero
      assign rows_d[r] = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_o    <= 1'b0;
         rows_o <= '0;
      end else begin
         v_o    <= v_i;
         rows_o <= rows_d;
      end
   end

   function automatic logic [W-1:0] row_total(input logic [ROWS-1:0][W-1:0] r);
      logic [W-1:0] t;
      t = '0;
      for (int i = 0; i < ROWS; i++) t = t + r[i];
      return t;
   endfunction

   a_r2_level_valid: assert property (@(posedge clk) disable iff (!rst_n)
      v_o == $past(v_i));

   a_r7_sum_kept: assert property (@(posedge clk) disable iff (!rst_n)
      v_o |-> (row_total(rows_o) == $past(row_total(rows_i))));
endmodule

// File: rtl/csa_mul_final.sv
module csa_mul_final #(
   parameter int W = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 v_i,
   input  logic [1:0][W-1:0]    rows_i,
   output logic                 v_o,
   output logic [W-1:0]         sum_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_o   <= 1'b0;
         sum_o <= '0;
      end else begin
         v_o   <= v_i;
         sum_o <= rows_i[0] + rows_i[1];
      end
   end

   a_r2_final_valid: assert property (@(posedge clk) disable iff (!rst_n)
      v_o == $past(v_i));
endmodule

// File: rtl/csa_mul_top.sv
module csa_mul_top #(
   parameter int A_W = 8,
   parameter int B_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   input  logic [A_W-1:0]     a,
   input  logic [B_W-1:0]     b,
   output logic               out_valid,
   output logic [A_W+B_W-1:0] product
);
   localparam int PW   = A_W + B_W;
   localparam int NLEV = csa_mul_pkg::num_levels(B_W);
   localparam int LAT  = NLEV + 2;

   if (A_W < 1)  begin : g_bad_a $error("csa_mul_top: A_W must be at least 1"); end
   if (B_W < 2)  begin : g_bad_b $error("csa_mul_top: B_W must be at least 2"); end
   if (LAT > 16) begin : g_bad_l $error("csa_mul_top: tree too deep"); end

   logic [NLEV:0]          vld_s;
   logic [B_W-1:0][PW-1:0] rows_s [NLEV+1];

   csa_mul_pp #(.A_W(A_W), .B_W(B_W), .W(PW)) u_pp (
      .clk    (clk),
      .rst_n  (rst_n),
      .v_i    (in_valid),
      .a_i    (a),
      .b_i    (b),
      .v_o    (vld_s[0]),
      .rows_o (rows_s[0])
   );

   for (genvar l = 0; l < NLEV; l++) begin : g_lvl
      csa_mul_level #(
         .W    (PW),
         .ROWS (B_W),
         .N_IN (csa_mul_pkg::level_rows(B_W, l))
      ) u_level (
         .clk    (clk),
         .rst_n  (rst_n),
         .v_i    (vld_s[l]),
         .rows_i (rows_s[l]),
         .v_o    (vld_s[l+1]),
         .rows_o (rows_s[l+1])
      );
   end

   csa_mul_final #(.W(PW)) u_final (
      .clk    (clk),
      .rst_n  (rst_n),
      .v_i    (vld_s[NLEV]),
      .rows_i (rows_s[NLEV][1:0]),
      .v_o    (out_valid),
      .sum_o  (product)
   );

   // R1: end-to-end value against the operands accepted LAT edges earlier.
   a_r1_product: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (product == (PW'($past(a, LAT)) * PW'($past(b, LAT)))));

   // R4: nothing valid at the output during reset.
   a_r4_reset_quiet: assert property (@(posedge clk)
      !rst_n |-> !out_valid);
endmodule

// File: tb/csa_mul_top_tb_top.sv
`timescale 1ns/1ps
module csa_mul_top_tb_top;
   localparam int LAT = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [7:0]  a = '0;
   logic [7:0]  b = '0;
   logic        out_valid;
   logic [15:0] product;

   always #2.5 clk = ~clk;

   csa_mul_top dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .a         (a),
      .b         (b),
      .out_valid (out_valid),
      .product   (product)
   );

   typedef struct {
      logic [15:0] val;
      int          stamp;
      string       tag;
   } item_t;

   item_t q[$];
   int    cyc = 0;
   int    checks = 0;
   int    errors = 0;
   bit    run_mon = 1'b0;
   bit    done = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic drive(input int av, input int bv, input string tag);
      item_t it;
      @(negedge clk);
      a = av[7:0];
      b = bv[7:0];
      in_valid = 1'b1;
      it.val   = 16'(av * bv);
      it.stamp = cyc;
      it.tag   = tag;
      q.push_back(it);
   endtask

   task automatic idle(input int n);
      repeat (n) begin
         @(negedge clk);
         in_valid = 1'b0;
      end
   endtask

   // Monitor: the valid flag must match the scoreboard slot in every cycle (R2, R5),
   // and the value must match the stored product (R1 and the item's own tag).
   always @(negedge clk) begin
      if (run_mon) begin
         bit exp_v;
         exp_v = (q.size() != 0) && (q[0].stamp + LAT == cyc);
         check(out_valid == exp_v, "R2/R5", "out_valid slot",
               int'(out_valid), int'(exp_v));
         if (out_valid && exp_v) begin
            item_t it;
            it = q.pop_front();
            check(product == it.val, it.tag, "product",
                  int'(product), int'(it.val));
         end
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R4: outputs are quiet during reset
      check(out_valid == 1'b0, "R4", "out_valid in reset", int'(out_valid), 0);
      check(product == 16'd0, "R4", "product in reset", int'(product), 0);
      rst_n = 1'b1;
      run_mon = 1'b1;
      idle(10);
      check(out_valid == 1'b0, "R4", "out_valid before first pair",
            int'(out_valid), 0);

      // R8: extreme operands
      drive(0, 0, "R8");
      drive(0, 255, "R8");
      drive(255, 0, "R8");
      drive(1, 173, "R8");
      drive(255, 255, "R8");
      idle(3);
      // R6: multiplier with a single bit set
      for (int i = 0; i < 8; i++) drive(8'hB5, 1 << i, "R6");
      idle(2);
      // R7: rows of all ones produce the longest carries
      drive(255, 255, "R7");
      idle(1);
      drive(255, 255, "R7");
      drive(254, 255, "R7");
      drive(255, 127, "R7");
      // R5: isolated pairs separated by gaps
      drive(3, 5, "R5");
      idle(4);
      drive(200, 100, "R5");
      idle(9);

      // R1 / R3: every pair back to back, with a bubble after every 97th
      for (int i = 0; i < 65536; i++) begin
         drive(i >> 8, i & 255, "R1/R3");
         if (i % 97 == 0) idle(1);
      end
      idle(LAT + 6);
      check(q.size() == 0, "R2", "pairs left undelivered", q.size(), 0);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule